// File: doc/BRIEF.md
# Processor-to-Memory Crossbar Switch

This block joins a set of processor request ports to a set of memory-module ports through a full grid of crosspoints. Each processor presents an address, a write flag, write data and a valid strobe. The upper address bits name the target module and the remaining bits name a word inside that module. Every module has its own arbiter. When several processors aim at one module in the same cycle, that arbiter picks one of them by a fixed order, and the lowest processor index wins.

Requests to different modules are granted together in the same cycle, because each module has its own path. Multiplexers controlled by the grants send the address and write data toward each module. They also send each module's read data back to the processor that issued the read. Grants are combinational. A granted write is performed at the clock edge that ends the grant cycle. A granted read returns its data one cycle later, together with a read-valid pulse. A processor that loses keeps its request raised until it receives a grant.

Top module: `xbar_top`

## Requirements
- R1: The module index of a request is the top log2(NMEM) bits of its AW-bit address. The low AW-log2(NMEM) bits appear unchanged on that module's `mem_addr` field while the request is granted.
- R2: A valid request is granted in the same cycle whenever no lower-numbered processor targets the same module in that cycle.
- R3: No module grants more than one processor per cycle. Among the processors targeting a module, the lowest index is the one granted.
- R4: A processor without a valid request, or one that loses arbitration, sees `gnt` low. Its write data never reaches memory.
- R5: Processors that target pairwise distinct modules are all granted in the same cycle.
- R6: A granted write (`req_write`=1) raises `mem_en` and `mem_we` of its module in the grant cycle with the processor's data. A later read of that word returns the data.
- R7: A granted read (`req_write`=0) raises `rvalid` of that processor exactly one cycle after the grant, and `rdata` carries the addressed word. At all other times `rvalid` is low.
- R8: When no processor has a valid request, every `mem_en` is low and every `gnt` is low.
- R9: While `rst_n` is low, and in the first cycle after reset, every `rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NPROC | Request strobe, one bit per processor |
| req_write | input | NPROC | 1 = write, 0 = read, per processor |
| req_addr | input | NPROC*AW | Packed processor addresses, processor p at bits p*AW |
| req_wdata | input | NPROC*DW | Packed processor write data |
| gnt | output | NPROC | Combinational grant per processor |
| rvalid | output | NPROC | Read data valid, one cycle after a read grant |
| rdata | output | NPROC*DW | Packed read data returned per processor |
| mem_en | output | NMEM | Access strobe per memory module |
| mem_we | output | NMEM | Write enable per memory module |
| mem_addr | output | NMEM*(AW-log2(NMEM)) | Packed word address per module |
| mem_wdata | output | NMEM*DW | Packed write data per module |
| mem_rdata | input | NMEM*DW | Packed registered read data from each module |

## Verification
The hardest case to reach from the ports is a lower-priority processor that keeps losing, with several modules under contention at once, while its pending request is held unchanged and later completes against a memory image that the winners have already changed. The stimulus holds every losing request fixed until it is granted, and it biases addresses toward a narrow set of modules so that conflicts pile up. A directed sequence then has all processors write the same module and releases them one at a time, so each priority level wins in turn. Reads that follow confirm that only the granted writes changed memory.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    function automatic int sel_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
    parameter int AW   = 6,
    parameter int NMEM = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 valid,
    input  logic [AW-1:0]                        addr,
    output logic [NMEM-1:0]                      hit,
    output logic [AW-xbar_pkg::sel_bits(NMEM)-1:0] word
);
    localparam int MSEL_W = xbar_pkg::sel_bits(NMEM);
    localparam int WAW    = AW - MSEL_W;

    logic [MSEL_W-1:0] msel;

    assign msel = addr[AW-1 -: MSEL_W];
    assign word = addr[WAW-1:0];

    // one crosspoint compare per module column
    for (genvar m = 0; m < NMEM; m++) begin : g_cmp
        assign hit[m] = valid && (msel == MSEL_W'(m));
    end

    assert_hit_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $onehot(hit));
    assert_hit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (hit == '0));

endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter #(
    parameter int NPROC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPROC-1:0] req,
    output logic [NPROC-1:0] gnt
);
    logic taken;

    // fixed order: index 0 strongest
    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int p = 0; p < NPROC; p++) begin
            if (req[p] && !taken) begin
                gnt[p] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_top_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> gnt[0]);
    assert_grant_requested_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    assert_work_conserving_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (gnt != '0));

endmodule

// File: rtl/xbar_return.sv
module xbar_return #(
    parameter int NPROC = 4,
    parameter int NMEM  = 4,
    parameter int DW    = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NPROC-1:0]                        rd_take,
    input  logic [NPROC*xbar_pkg::sel_bits(NMEM)-1:0] rd_sel,
    input  logic [NMEM*DW-1:0]                      mem_rdata,
    output logic [NPROC-1:0]                        rvalid,
    output logic [NPROC*DW-1:0]                     rdata
);
    localparam int MSEL_W = xbar_pkg::sel_bits(NMEM);

    typedef struct packed {
        logic [NPROC-1:0]             pend;
        logic [NPROC-1:0][MSEL_W-1:0] src;
    } ret_t;

    ret_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pend = rd_take;
        for (int p = 0; p < NPROC; p++) begin
            st_d.src[p] = rd_sel[p*MSEL_W +: MSEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // return-path multiplexer steered by the registered module index
    always_comb begin
        rdata = '0;
        for (int p = 0; p < NPROC; p++) begin
            if (st_q.pend[p]) begin
                rdata[p*DW +: DW] = mem_rdata[int'(st_q.src[p])*DW +: DW];
            end
        end
    end

    assign rvalid = st_q.pend;

    assert_rvalid_follows_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid != '0) |-> ($past(rd_take) == rvalid));

endmodule

// File: rtl/xbar_top.sv
module xbar_top #(
    parameter int NPROC = 4,
    parameter int NMEM  = 4,
    parameter int AW    = 6,
    parameter int DW    = 16
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NPROC-1:0]                              req_valid,
    input  logic [NPROC-1:0]                              req_write,
    input  logic [NPROC*AW-1:0]                           req_addr,
    input  logic [NPROC*DW-1:0]                           req_wdata,
    output logic [NPROC-1:0]                              gnt,
    output logic [NPROC-1:0]                              rvalid,
    output logic [NPROC*DW-1:0]                           rdata,
    output logic [NMEM-1:0]                               mem_en,
    output logic [NMEM-1:0]                               mem_we,
    output logic [NMEM*(AW-xbar_pkg::sel_bits(NMEM))-1:0] mem_addr,
    output logic [NMEM*DW-1:0]                            mem_wdata,
    input  logic [NMEM*DW-1:0]                            mem_rdata
);
    import xbar_pkg::*;

    localparam int MSEL_W = sel_bits(NMEM);
    localparam int WAW    = AW - MSEL_W;

    logic [NMEM-1:0]     hit     [NPROC];
    logic [WAW-1:0]      word    [NPROC];
    logic [NPROC-1:0]    col_req [NMEM];
    logic [NPROC-1:0]    col_gnt [NMEM];
    logic [NPROC-1:0]    rd_take;
    logic [NPROC*MSEL_W-1:0] rd_sel;

    // row side: address decode per processor bus
    for (genvar p = 0; p < NPROC; p++) begin : g_row
        xbar_decode #(.AW(AW), .NMEM(NMEM)) u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (req_valid[p]),
            .addr  (req_addr[p*AW +: AW]),
            .hit   (hit[p]),
            .word  (word[p])
        );
        assign rd_sel[p*MSEL_W +: MSEL_W] = req_addr[p*AW + AW - 1 -: MSEL_W];
    end

    // transpose hits into per-module request columns
    always_comb begin
        for (int m = 0; m < NMEM; m++) begin
            for (int p = 0; p < NPROC; p++) begin
                col_req[m][p] = hit[p][m];
            end
        end
    end

    // column side: one arbiter per memory module
    for (genvar m = 0; m < NMEM; m++) begin : g_col
        xbar_arbiter #(.NPROC(NPROC)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (col_req[m]),
            .gnt   (col_gnt[m])
        );
    end

    // forward multiplexers and grant collection
    always_comb begin
        gnt       = '0;
        mem_en    = '0;
        mem_we    = '0;
        mem_addr  = '0;
        mem_wdata = '0;
        for (int m = 0; m < NMEM; m++) begin
            for (int p = 0; p < NPROC; p++) begin
                if (col_gnt[m][p]) begin
                    gnt[p]                     = 1'b1;
                    mem_en[m]                  = 1'b1;
                    mem_we[m]                  = req_write[p];
                    mem_addr[m*WAW +: WAW]     = word[p];
                    mem_wdata[m*DW +: DW]      = req_wdata[p*DW +: DW];
                end
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NPROC; p++) begin
            rd_take[p] = gnt[p] && (op_e'(req_write[p]) == OP_READ);
        end
    end

    xbar_return #(.NPROC(NPROC), .NMEM(NMEM), .DW(DW)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_take   (rd_take),
        .rd_sel    (rd_sel),
        .mem_rdata (mem_rdata),
        .rvalid    (rvalid),
        .rdata     (rdata)
    );

    for (genvar p = 0; p < NPROC; p++) begin : g_chk
        assert_gnt_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[p] |-> req_valid[p]);
        assert_read_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[p] && !req_write[p]) |=> rvalid[p]);
        assert_no_stray_rvalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rvalid[p] |-> $past(gnt[p] && !req_write[p]));
        assert_write_reaches_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[p] && req_write[p]) |->
                (mem_we[req_addr[p*AW + AW - 1 -: MSEL_W]] &&
                 mem_wdata[int'(req_addr[p*AW + AW - 1 -: MSEL_W])*DW +: DW]
                     == req_wdata[p*DW +: DW]));
    end

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == '0) |-> (mem_en == '0 && gnt == '0));

endmodule

// File: tb/xbar_top_bench.sv
module xbar_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP    = 4;
    localparam int NM    = 4;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int MS    = 2;
    localparam int WAW   = AW - MS;
    localparam int DEPTH = 1 << WAW;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      req_valid = '0;
    logic [NP-1:0]      req_write = '0;
    logic [NP*AW-1:0]   req_addr = '0;
    logic [NP*DW-1:0]   req_wdata = '0;
    logic [NP-1:0]      gnt, rvalid;
    logic [NP*DW-1:0]   rdata;
    logic [NM-1:0]      mem_en, mem_we;
    logic [NM*WAW-1:0]  mem_addr;
    logic [NM*DW-1:0]   mem_wdata, mem_rdata;

    int total = 0;
    int fails = 0;

    logic [DW-1:0] mem_arr [NM][DEPTH];
    logic [DW-1:0] mem_rd_q [NM];
    logic [DW-1:0] ref_mem [NM][DEPTH];

    logic [NP-1:0] exp_rv;
    logic [DW-1:0] exp_rd [NP];
    logic [NP-1:0] hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_top #(.NPROC(NP), .NMEM(NM), .AW(AW), .DW(DW)) u_xbar_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .gnt(gnt), .rvalid(rvalid),
        .rdata(rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] seed_val(input int m, input int w);
        return DW'(16'hA000 + m*256 + w*3);
    endfunction

    // behavioural memory modules, registered read
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < NM; m++) begin
                mem_rd_q[m] <= '0;
                for (int w = 0; w < DEPTH; w++) mem_arr[m][w] <= seed_val(m, w);
            end
        end else begin
            for (int m = 0; m < NM; m++) begin
                if (mem_en[m] && mem_we[m])
                    mem_arr[m][mem_addr[m*WAW +: WAW]] <= mem_wdata[m*DW +: DW];
                if (mem_en[m] && !mem_we[m])
                    mem_rd_q[m] <= mem_arr[m][mem_addr[m*WAW +: WAW]];
            end
        end
    end

    always_comb begin
        for (int m = 0; m < NM; m++) mem_rdata[m*DW +: DW] = mem_rd_q[m];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int mod_of(input int p);
        return int'(req_addr[p*AW + AW - 1 -: MS]);
    endfunction

    function automatic int word_of(input int p);
        return int'(req_addr[p*AW +: WAW]);
    endfunction

    // lowest-index valid processor targeting module m, or -1
    function automatic int winner(input int m);
        for (int p = 0; p < NP; p++)
            if (req_valid[p] && mod_of(p) == m) return p;
        return -1;
    endfunction

    task automatic set_req(input int p, input bit v, input bit wr, input int m,
                           input int w, input logic [DW-1:0] d);
        req_valid[p]            = v;
        req_write[p]            = wr;
        req_addr[p*AW +: AW]    = AW'((m << WAW) | w);
        req_wdata[p*DW +: DW]   = d;
    endtask

    // check returns of the previous cycle
    task automatic check_returns();
        for (int p = 0; p < NP; p++) begin
            chk(rvalid[p] == exp_rv[p], "R7 rvalid", 32'(rvalid[p]), 32'(exp_rv[p]));
            if (exp_rv[p])
                chk(rdata[p*DW +: DW] == exp_rd[p], "R7/R6 rdata",
                    32'(rdata[p*DW +: DW]), 32'(exp_rd[p]));
        end
    endtask

    // inputs already driven; evaluate grant cycle
    task automatic check_grants();
        logic [NP-1:0] exp_g;
        #1;
        exp_g = '0;
        exp_rv = '0;
        for (int m = 0; m < NM; m++) begin
            int wn;
            wn = winner(m);
            chk(mem_en[m] == (wn >= 0), "R8/R2 mem_en", 32'(mem_en[m]), 32'(wn >= 0));
            if (wn >= 0) begin
                exp_g[wn] = 1'b1;
                chk(mem_addr[m*WAW +: WAW] == WAW'(word_of(wn)), "R1 mem_addr",
                    32'(mem_addr[m*WAW +: WAW]), 32'(word_of(wn)));
                chk(mem_we[m] == req_write[wn], "R6 mem_we", 32'(mem_we[m]),
                    32'(req_write[wn]));
                if (req_write[wn]) begin
                    chk(mem_wdata[m*DW +: DW] == req_wdata[wn*DW +: DW], "R6 mem_wdata",
                        32'(mem_wdata[m*DW +: DW]), 32'(req_wdata[wn*DW +: DW]));
                    ref_mem[m][word_of(wn)] = req_wdata[wn*DW +: DW];
                end else begin
                    exp_rv[wn] = 1'b1;
                    exp_rd[wn] = ref_mem[m][word_of(wn)];
                end
            end
        end
        chk(gnt == exp_g, "R3/R4/R5 gnt", 32'(gnt), 32'(exp_g));
        hold = req_valid & ~exp_g;
    endtask

    task automatic cycle();
        @(negedge clk);
        check_returns();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        exp_rv = '0;
        hold   = '0;
        for (int p = 0; p < NP; p++) exp_rd[p] = '0;
        for (int m = 0; m < NM; m++)
            for (int w = 0; w < DEPTH; w++) ref_mem[m][w] = seed_val(m, w);

        // R9: rvalid low in reset
        repeat (3) @(negedge clk);
        chk(rvalid == '0, "R9 rvalid in reset", 32'(rvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rvalid == '0, "R9 rvalid after reset", 32'(rvalid), 0);

        // R8: idle
        check_grants();

        // R3/R4: all write module 2, released one by one from the top
        cycle();
        for (int p = 0; p < NP; p++) set_req(p, 1, 1, 2, 5, DW'(16'h1110 * (p + 1)));
        check_grants();
        chk(gnt == 4'b0001, "R3 lowest index wins", 32'(gnt), 1);
        for (int k = 0; k < NP - 1; k++) begin
            cycle();
            req_valid[k] = 1'b0;
            check_grants();
        end
        cycle();
        req_valid = '0;
        set_req(0, 1, 0, 2, 5, '0);
        check_grants();
        cycle();
        req_valid = '0;
        check_grants();
        chk(exp_rd[0] == 16'h4440, "R6 last granted write kept", 32'(exp_rd[0]), 32'h4440);

        // R5: distinct modules all at once, reads
        cycle();
        for (int p = 0; p < NP; p++) set_req(p, 1, 0, NP - 1 - p, p + 1, '0);
        check_grants();
        chk(gnt == 4'b1111, "R5 parallel grants", 32'(gnt), 32'hF);

        // R6/R7: write then read back the same word from another processor
        cycle();
        req_valid = '0;
        set_req(3, 1, 1, 1, 9, 16'hBEEF);
        check_grants();
        cycle();
        req_valid = '0;
        set_req(2, 1, 0, 1, 9, '0);
        check_grants();
        cycle();
        chk(rdata[2*DW +: DW] == 16'hBEEF, "R6 readback", 32'(rdata[2*DW +: DW]), 32'hBEEF);
        req_valid = '0;
        check_grants();

        // random phase with held losers
        hold = '0;
        for (int c = 0; c < 3000; c++) begin
            cycle();
            for (int p = 0; p < NP; p++) begin
                if (!hold[p]) begin
                    set_req(p, ($urandom % 4) != 0, $urandom % 2,
                            (($urandom % 3) == 0) ? int'($urandom % NM) : int'($urandom % 2),
                            int'($urandom % DEPTH), DW'($urandom));
                end
            end
            check_grants();
        end
        cycle();
        req_valid = '0;
        check_grants();
        cycle();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule